// File: doc/BRIEF.md
# Descriptor-list audio stream position engine

This block drives one audio stream's direct memory traffic from a list of buffer descriptors held in system memory. When software raises the run control, the engine fetches every descriptor of the list into local storage. Each descriptor gives a memory address, a byte length and a flags word. From then on a codec-side requester asks for transfers of N bytes by stream tag and direction. The engine breaks each request into memory bursts. No burst ever crosses the end of a descriptor or the end of the cyclic buffer.

The engine keeps three running values: the position within the cyclic buffer, the index of the current descriptor and the byte offset inside that descriptor. A descriptor whose completion flag is set raises a completion status once it has been fully consumed. While that status is pending, further requests are refused, so the requester cannot run past a buffer that software has not yet serviced. As an option, the engine also writes the buffer position back to a slot in a memory position table after every burst.

Top module: `stream_bdl_engine`

## Requirements
- R1: After `rst_n` is low or `ctl_srst` is pulsed, `lpib`, `cur_idx` and `cur_off` read 0 and `cmpl_pending` is 0. The loaded list is discarded, so later requests are refused until the next 0-to-1 edge of `ctl_run`.
- R2: On a 0-to-1 edge of `ctl_run` the engine issues `lvi`+1 memory reads with `mem_kind`=0 and `mem_len`=16, in ascending order, at `bdl_base`+16*i. Each returned `mem_rdata` is decoded as address = [63:0], length = [95:64] and completion flag = bit 96. The remaining flag bits [127:97] are ignored.
- R3: Every data burst is sized as the smallest of three values: the bytes still owed to the request, `cbl`−`lpib`, and the descriptor length minus `cur_off`. Its address is the descriptor address plus `cur_off`. Its `mem_kind` is 1 (memory read) when STREAM_IDX≥4 and 2 (memory write) otherwise.
- R4: `lpib` returns to 0 when it reaches `cbl`. When a descriptor is used up, `cur_off` returns to 0 and `cur_idx` steps to the next descriptor, going from `lvi` back to 0.
- R5: When `pos_base[0]`=1, every data burst is followed by one write with `mem_kind`=3 and `mem_len`=4. Its address is `pos_base` with bit 0 cleared plus 8*STREAM_IDX, and `mem_wdata` carries the updated `lpib`. When `pos_base[0]`=0, no such write is made.
- R6: If a request consumes to its end any descriptor whose completion flag is set, `cmpl_pending` rises in the same cycle as that request's acknowledge.
- R7: While `cmpl_pending` is 1, every request is refused. A one-cycle pulse on `cmpl_clr` clears the status, and requests are then accepted again.
- R8: A request is refused in any of these cases: `ctl_run` is 0, no list is loaded, `xfer_tag`≠`ctl_tag`, `xfer_out` does not match the stream direction (STREAM_IDX≥4 means output), or `cbl` is 0. A refused request receives `xfer_ack` with `xfer_ok`=0 in the cycle after it is seen. It causes no memory access and leaves the position outputs unchanged.
- R9: An accepted request is acknowledged with `xfer_ok`=1 only after all of its bursts have been granted. A zero-byte request is acknowledged with no memory access. `mem_req` and its address stay steady until `mem_ack`, and `xfer_ack` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_run | input | 1 | Stream run control; its rising edge loads the list |
| ctl_srst | input | 1 | Stream reset pulse |
| ctl_tag | input | 4 | Stream tag this engine answers to |
| cbl | input | 32 | Cyclic buffer length in bytes |
| lvi | input | 8 | Index of the last valid descriptor |
| bdl_base | input | 64 | Descriptor list base address |
| pos_base | input | 64 | Position table base; bit 0 enables write-back |
| cmpl_clr | input | 1 | Write-one pulse clearing completion status |
| xfer_req | input | 1 | Transfer request, held until acknowledged |
| xfer_tag | input | 4 | Requested stream tag |
| xfer_out | input | 1 | Requested direction, 1 = output |
| xfer_len | input | 32 | Requested byte count |
| xfer_ack | output | 1 | One-cycle acknowledge |
| xfer_ok | output | 1 | 1 = request served, 0 = refused |
| mem_req | output | 1 | Memory access request |
| mem_kind | output | 2 | 0 list read, 1 data read, 2 data write, 3 position write |
| mem_addr | output | 64 | Memory byte address |
| mem_len | output | 32 | Access length in bytes |
| mem_wdata | output | 32 | Position value for position writes |
| mem_ack | input | 1 | Memory grant, one cycle |
| mem_rdata | input | 128 | Descriptor returned by a list read |
| lpib | output | 32 | Position in cyclic buffer |
| cur_idx | output | 8 | Current descriptor index |
| cur_off | output | 32 | Offset within current descriptor |
| cmpl_pending | output | 1 | Buffer completion pending |

## Verification
A request is sampled at a clock edge. A refusal is answered in the next cycle. An accepted request raises its first `mem_req` in that same next cycle, and then takes one state step per granted burst, plus one step per position write, before `xfer_ack` appears. The positions and `cmpl_pending` are final in the acknowledge cycle itself. For this reason the bench does not predict cycle counts. It samples at the falling edge. Each burst is compared with a byte-stepped model at the moment the bench memory grants it. The acknowledge values are compared in the first falling edge where `xfer_ack` is high. An empty expectation queue at that point shows that no burst arrived after the acknowledge.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

  typedef enum logic [1:0] {
    MK_DESC = 2'd0,
    MK_RD   = 2'd1,
    MK_WR   = 2'd2,
    MK_POS  = 2'd3
  } mem_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_BURST,
    ST_POS,
    ST_ACK
  } eng_state_e;

  function automatic logic [31:0] min3(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input logic [31:0] c);
    logic [31:0] m;
    m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  function automatic logic [31:0] wrap_add(input logic [31:0] pos,
                                           input logic [31:0] step,
                                           input logic [31:0] limit);
    logic [31:0] s;
    s = pos + step;
    return (s == limit) ? 32'd0 : s;
  endfunction

endpackage

// File: rtl/bdl_desc_ram.sv
module bdl_desc_ram #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [LEN_W-1:0]  w_len,
  input  logic              w_ioc,
  input  logic [IDX_W-1:0]  raddr,
  output logic [ADDR_W-1:0] r_addr,
  output logic [LEN_W-1:0]  r_len,
  output logic              r_ioc
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [LEN_W-1:0]  len_mem  [DEPTH];
  logic [DEPTH-1:0]  ioc_mem;

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[waddr] <= w_addr;
      len_mem[waddr]  <= w_len;
      ioc_mem[waddr]  <= w_ioc;
    end
  end

  assign r_addr = addr_mem[raddr];
  assign r_len  = len_mem[raddr];
  assign r_ioc  = ioc_mem[raddr];
endmodule

// File: rtl/bdl_chunk_unit.sv
module bdl_chunk_unit
  import bdl_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [31:0]      left,
  input  logic [31:0]      lpib,
  input  logic [31:0]      cbl,
  input  logic [31:0]      bp,
  input  logic [31:0]      dlen,
  input  logic [IDX_W-1:0] be,
  input  logic [IDX_W-1:0] last,
  output logic [31:0]      chunk,
  output logic [31:0]      lpib_nxt,
  output logic [31:0]      bp_nxt,
  output logic [IDX_W-1:0] be_nxt,
  output logic             desc_end
);
  always_comb begin
    chunk    = min3(left, cbl - lpib, dlen - bp);
    lpib_nxt = wrap_add(lpib, chunk, cbl);
    desc_end = ((bp + chunk) == dlen);
    bp_nxt   = desc_end ? 32'd0 : bp + chunk;
    if (!desc_end)       be_nxt = be;
    else if (be == last) be_nxt = '0;
    else                 be_nxt = be + 1'b1;
  end
endmodule

// File: rtl/stream_bdl_engine.sv
module stream_bdl_engine
  import bdl_pkg::*;
#(
  parameter int STREAM_IDX = 5,
  parameter int MAX_DESC   = 256,
  parameter int ADDR_W     = 64,
  parameter int TAG_W      = 4,
  localparam int IDX_W     = $clog2(MAX_DESC),
  localparam bit IS_OUT    = (STREAM_IDX >= 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_run,
  input  logic              ctl_srst,
  input  logic [TAG_W-1:0]  ctl_tag,
  input  logic [31:0]       cbl,
  input  logic [IDX_W-1:0]  lvi,
  input  logic [ADDR_W-1:0] bdl_base,
  input  logic [ADDR_W-1:0] pos_base,
  input  logic              cmpl_clr,
  input  logic              xfer_req,
  input  logic [TAG_W-1:0]  xfer_tag,
  input  logic              xfer_out,
  input  logic [31:0]       xfer_len,
  output logic              xfer_ack,
  output logic              xfer_ok,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_len,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [127:0]      mem_rdata,
  output logic [31:0]       lpib,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [31:0]       cur_off,
  output logic              cmpl_pending
);
  eng_state_e       state;
  logic             run_q, loaded, pend_req, ok_r, cmpl_r;
  logic [IDX_W-1:0] ld_idx, be;
  logic [31:0]      bp, lpib_r, left;

  logic [ADDR_W-1:0] d_addr;
  logic [31:0]       d_len;
  logic              d_ioc;
  logic [31:0]       chunk, lpib_nxt, bp_nxt;
  logic [IDX_W-1:0]  be_nxt;
  logic              desc_end;

  // named internal events
  logic run_rise, refuse, burst_done, skip_desc, data_phase, load_done;
  logic [30:0] flags_unused;
  assign flags_unused = mem_rdata[127:97];

  assign run_rise   = ctl_run && !run_q;
  assign refuse     = !ctl_run || !loaded || (xfer_tag != ctl_tag) ||
                      (xfer_out != IS_OUT) || cmpl_r || (cbl == 32'd0);
  assign data_phase = (state == ST_BURST) && (left != 32'd0);
  assign skip_desc  = data_phase && (chunk == 32'd0);
  assign burst_done = data_phase && (chunk != 32'd0) && mem_ack;
  assign load_done  = (state == ST_LOAD) && mem_ack && (ld_idx == lvi);

  bdl_desc_ram #(.DEPTH(MAX_DESC), .ADDR_W(ADDR_W), .LEN_W(32)) u_ram (
    .clk    (clk),
    .we     ((state == ST_LOAD) && mem_ack),
    .waddr  (ld_idx),
    .w_addr (mem_rdata[ADDR_W-1:0]),
    .w_len  (mem_rdata[95:64]),
    .w_ioc  (mem_rdata[96]),
    .raddr  (be),
    .r_addr (d_addr),
    .r_len  (d_len),
    .r_ioc  (d_ioc)
  );

  bdl_chunk_unit #(.IDX_W(IDX_W)) u_chunk (
    .left     (left),
    .lpib     (lpib_r),
    .cbl      (cbl),
    .bp       (bp),
    .dlen     (d_len),
    .be       (be),
    .last     (lvi),
    .chunk    (chunk),
    .lpib_nxt (lpib_nxt),
    .bp_nxt   (bp_nxt),
    .be_nxt   (be_nxt),
    .desc_end (desc_end)
  );

  always_comb begin
    mem_req  = 1'b0;
    mem_kind = MK_DESC;
    mem_addr = '0;
    mem_len  = 32'd0;
    unique case (state)
      ST_LOAD: begin
        mem_req  = 1'b1;
        mem_kind = MK_DESC;
        mem_addr = bdl_base + (ADDR_W'(ld_idx) << 4);
        mem_len  = 32'd16;
      end
      ST_BURST: begin
        mem_req  = data_phase && (chunk != 32'd0);
        mem_kind = IS_OUT ? MK_RD : MK_WR;
        mem_addr = d_addr + ADDR_W'(bp);
        mem_len  = chunk;
      end
      ST_POS: begin
        mem_req  = 1'b1;
        mem_kind = MK_POS;
        mem_addr = {pos_base[ADDR_W-1:1], 1'b0} + ADDR_W'(8 * STREAM_IDX);
        mem_len  = 32'd4;
      end
      default: ;
    endcase
  end

  assign mem_wdata    = lpib_r;
  assign xfer_ack     = (state == ST_ACK);
  assign xfer_ok      = xfer_ack && ok_r;
  assign lpib         = lpib_r;
  assign cur_idx      = be;
  assign cur_off      = bp;
  assign cmpl_pending = cmpl_r;

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_srst) begin
      state    <= ST_IDLE;
      run_q    <= rst_n ? ctl_run : 1'b0;
      loaded   <= 1'b0;
      pend_req <= 1'b0;
      ok_r     <= 1'b0;
      cmpl_r   <= 1'b0;
      ld_idx   <= '0;
      be       <= '0;
      bp       <= 32'd0;
      lpib_r   <= 32'd0;
      left     <= 32'd0;
    end else begin
      run_q <= ctl_run;
      if (cmpl_clr) cmpl_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (run_rise) begin
            state  <= ST_LOAD;
            ld_idx <= '0;
            loaded <= 1'b0;
          end else if (xfer_req) begin
            ok_r <= !refuse;
            if (refuse) begin
              state <= ST_ACK;
            end else begin
              state    <= ST_BURST;
              left     <= xfer_len;
              pend_req <= 1'b0;
            end
          end
        end
        ST_LOAD: begin
          if (mem_ack) begin
            ld_idx <= ld_idx + 1'b1;
            if (load_done) begin
              loaded <= 1'b1;
              be     <= '0;
              bp     <= 32'd0;
              state  <= ST_IDLE;
            end
          end
        end
        ST_BURST: begin
          if (left == 32'd0) begin
            state <= ST_ACK;
            if (pend_req) cmpl_r <= 1'b1;
          end else if (skip_desc) begin
            bp <= bp_nxt;
            be <= be_nxt;
            if (desc_end && d_ioc) pend_req <= 1'b1;
          end else if (burst_done) begin
            left   <= left - chunk;
            lpib_r <= lpib_nxt;
            bp     <= bp_nxt;
            be     <= be_nxt;
            if (desc_end && d_ioc) pend_req <= 1'b1;
            if (pos_base[0]) state <= ST_POS;
          end
        end
        ST_POS: begin
          if (mem_ack) state <= ST_BURST;
        end
        ST_ACK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_burst_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (mem_kind == MK_RD || mem_kind == MK_WR)) |->
      (mem_len != 32'd0) && (mem_len <= left) &&
      (bp + mem_len <= d_len) && (lpib_r + mem_len <= cbl));

  assert_lpib_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n || ctl_srst)
    (mem_req && mem_ack && (mem_kind == MK_RD || mem_kind == MK_WR)) |=> (lpib < cbl));

  assert_pos_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind == MK_POS) |-> (pos_base[0] && (mem_wdata < cbl)));

  assert_cmpl_at_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_pending) |-> (xfer_ack && xfer_ok));

  assert_cmpl_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || ctl_srst)
    (cmpl_pending && !cmpl_clr) |=> cmpl_pending);

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || ctl_srst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_kind)));

endmodule

// File: tb/stream_bdl_engine_test.sv
module stream_bdl_engine_test;
  localparam int SIDX = 5;
  localparam int NDESC = 4;
  localparam logic [63:0] BDL_BASE = 64'h0000_0040_0000_0100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ctl_run = 1'b0, ctl_srst = 1'b0, cmpl_clr = 1'b0;
  logic [3:0] ctl_tag = 4'd5, xfer_tag = 4'd0;
  logic [31:0] cbl = 32'd150, xfer_len = 32'd0;
  logic [7:0] lvi = 8'd3;
  logic [63:0] bdl_base = BDL_BASE, pos_base = 64'h0;
  logic xfer_req = 1'b0, xfer_out = 1'b0;
  logic xfer_ack, xfer_ok, mem_req, mem_ack = 1'b0;
  logic [1:0] mem_kind;
  logic [63:0] mem_addr;
  logic [31:0] mem_len, mem_wdata, lpib, cur_off;
  logic [127:0] mem_rdata = '0;
  logic [7:0] cur_idx;
  logic cmpl_pending;

  stream_bdl_engine #(.STREAM_IDX(SIDX)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_srst(ctl_srst),
    .ctl_tag(ctl_tag), .cbl(cbl), .lvi(lvi), .bdl_base(bdl_base),
    .pos_base(pos_base), .cmpl_clr(cmpl_clr), .xfer_req(xfer_req),
    .xfer_tag(xfer_tag), .xfer_out(xfer_out), .xfer_len(xfer_len),
    .xfer_ack(xfer_ack), .xfer_ok(xfer_ok), .mem_req(mem_req),
    .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lpib(lpib), .cur_idx(cur_idx), .cur_off(cur_off),
    .cmpl_pending(cmpl_pending)
  );

  int n_cmp = 0, n_bad = 0;

  // descriptor table held by the bench memory
  longint unsigned d_adr [NDESC];
  int d_len [NDESC];
  bit d_ioc [NDESC];

  // reference model state
  int m_lpib = 0, m_be = 0, m_bp = 0;
  bit m_pend = 0, m_loaded = 0;

  int q_kind[$];
  longint unsigned q_addr[$];
  int q_len[$];
  int q_wd[$];

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(input int k);
    if (k == 0) return "R2";
    if (k == 3) return "R5";
    return "R3";
  endfunction

  // byte-stepped model of one accepted request
  task automatic model_xfer(input int n);
    longint unsigned baddr = 0;
    int blen = 0;
    bit pend = 0;
    for (int k = 0; k < n; k++) begin
      bit bound;
      int guard = 0;
      while (d_len[m_be] == 0 && guard < NDESC) begin
        if (d_ioc[m_be]) pend = 1;
        m_be = (m_be == NDESC - 1) ? 0 : m_be + 1;
        guard++;
      end
      if (blen == 0) baddr = d_adr[m_be] + longint'(m_bp);
      blen++; m_bp++; m_lpib++;
      bound = (k == n - 1);
      if (m_lpib == int'(cbl)) begin m_lpib = 0; bound = 1; end
      if (m_bp == d_len[m_be]) begin
        if (d_ioc[m_be]) pend = 1;
        m_bp = 0;
        m_be = (m_be == NDESC - 1) ? 0 : m_be + 1;
        bound = 1;
      end
      if (bound) begin
        q_kind.push_back(1); q_addr.push_back(baddr); q_len.push_back(blen); q_wd.push_back(0);
        if (pos_base[0]) begin
          q_kind.push_back(3);
          q_addr.push_back({pos_base[63:1], 1'b0} + 64'(8 * SIDX));
          q_len.push_back(4); q_wd.push_back(m_lpib);
        end
        blen = 0;
      end
    end
    if (pend) m_pend = 1;
  endtask

  // bench memory: grants after a varying latency and checks each access
  int lat = 0, grants = 0;
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && rst_n) begin
      lat++;
      if (lat >= 1 + (grants % 3)) begin
        lat = 0; grants++;
        if (q_kind.size() == 0) begin
          check("R9", "unexpected memory access", mem_addr, 64'hDEAD);
        end else begin
          int k;
          longint unsigned a;
          int l, w;
          k = q_kind.pop_front(); a = q_addr.pop_front();
          l = q_len.pop_front(); w = q_wd.pop_front();
          check(kind_req(k), "mem_kind", 64'(mem_kind), 64'(k));
          check(kind_req(k), "mem_addr", mem_addr, a);
          check(kind_req(k), "mem_len", 64'(mem_len), 64'(l));
          if (k == 3) check("R5", "mem_wdata", 64'(mem_wdata), 64'(w));
        end
        if (mem_kind == 2'd0) begin
          int idx;
          idx = int'((mem_addr - BDL_BASE) >> 4);
          if (idx < 0 || idx >= NDESC) idx = 0;
          // upper flag bits carry junk that must be ignored (R2)
          mem_rdata = {31'h2A5B_0C1D, d_ioc[idx], 32'(d_len[idx]), 64'(d_adr[idx])};
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic do_xfer(input logic [3:0] tag, input bit out, input int n);
    bit exp_ok;
    exp_ok = ctl_run && m_loaded && (tag == ctl_tag) && (out == 1'b1) &&
             !m_pend && (cbl != 0);
    if (exp_ok) model_xfer(n);
    @(negedge clk);
    xfer_req = 1'b1; xfer_tag = tag; xfer_out = out; xfer_len = 32'(n);
    forever begin
      @(negedge clk);
      if (xfer_ack) break;
    end
    check(exp_ok ? "R9" : "R8", "xfer_ok", 64'(xfer_ok), 64'(exp_ok));
    check("R4", "lpib", 64'(lpib), 64'(m_lpib));
    check("R4", "cur_idx", 64'(cur_idx), 64'(m_be));
    check("R4", "cur_off", 64'(cur_off), 64'(m_bp));
    check(m_pend ? "R6" : "R7", "cmpl_pending", 64'(cmpl_pending), 64'(m_pend));
    check("R9", "bursts left at ack", 64'(q_kind.size()), 64'd0);
    xfer_req = 1'b0;
  endtask

  task automatic clear_cmpl();
    @(negedge clk); cmpl_clr = 1'b1;
    @(negedge clk); cmpl_clr = 1'b0;
    m_pend = 0;
    check("R7", "cmpl_pending after clear", 64'(cmpl_pending), 64'd0);
  endtask

  task automatic start_run();
    @(negedge clk); ctl_run = 1'b0;
    @(negedge clk); ctl_run = 1'b1;
    for (int i = 0; i < NDESC; i++) begin
      q_kind.push_back(0); q_addr.push_back(BDL_BASE + 64'(16 * i));
      q_len.push_back(16); q_wd.push_back(0);
    end
    while (q_kind.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    m_loaded = 1; m_be = 0; m_bp = 0;
    check("R2", "cur_idx after load", 64'(cur_idx), 64'd0);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    d_adr[0] = 64'h0000_0010_0000_0000; d_len[0] = 48; d_ioc[0] = 0;
    d_adr[1] = 64'h0000_0010_0000_1000; d_len[1] = 64; d_ioc[1] = 1;
    d_adr[2] = 64'h0000_0010_0000_2000; d_len[2] = 40; d_ioc[2] = 0;
    d_adr[3] = 64'h0000_0010_0000_3000; d_len[3] = 32; d_ioc[3] = 1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "lpib", 64'(lpib), 0);
    check("R1", "cur_idx", 64'(cur_idx), 0);
    check("R1", "cur_off", 64'(cur_off), 0);
    check("R1", "cmpl_pending", 64'(cmpl_pending), 0);
    check("R1", "mem_req", 64'(mem_req), 0);
    check("R1", "xfer_ack", 64'(xfer_ack), 0);

    do_xfer(4'd5, 1, 10);            // R8: run low
    start_run();                      // R2
    do_xfer(4'd3, 1, 10);            // R8: tag mismatch
    do_xfer(4'd5, 0, 10);            // R8: direction mismatch
    do_xfer(4'd5, 1, 20);            // R3 single burst
    do_xfer(4'd5, 1, 30);            // R4 crosses descriptor end
    do_xfer(4'd5, 1, 70);            // R6 flagged descriptor consumed
    do_xfer(4'd5, 1, 10);            // R7 refused while pending
    clear_cmpl();
    pos_base = 64'h0000_0000_2000_0001;
    do_xfer(4'd5, 1, 60);            // R4 cyclic wrap, R5 write-back
    do_xfer(4'd5, 1, 0);             // R9 zero-byte request
    for (int i = 0; i < 14; i++) begin
      pos_base[0] = i[0];
      do_xfer(4'd5, 1, (i * 37) % 90 + 1);
      if (m_pend) begin
        do_xfer(4'd5, 1, 5);         // R7 refused
        clear_cmpl();
      end
    end

    // R1: stream reset
    @(negedge clk); ctl_srst = 1'b1;
    @(negedge clk); ctl_srst = 1'b0;
    m_lpib = 0; m_be = 0; m_bp = 0; m_pend = 0; m_loaded = 0;
    check("R1", "lpib after srst", 64'(lpib), 0);
    check("R1", "cur_off after srst", 64'(cur_off), 0);
    check("R1", "cmpl after srst", 64'(cmpl_pending), 0);
    do_xfer(4'd5, 1, 8);             // R1/R8: list discarded

    start_run();
    cbl = 32'd0;
    do_xfer(4'd5, 1, 8);             // R8: zero cyclic length
    cbl = 32'd150;
    do_xfer(4'd5, 1, 25);
    do_xfer(4'd5, 1, 47);

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule